// File: doc/BRIEF.md
# Shared Free-Running Counter with Per-Target Compare Timers

This block keeps one up-counter that every CPU target in a cluster shares, plus one compare register per target. When the counter equals a target's compare value, that target's timer interrupt line is raised. The line stays high until software writes either half of that compare value. All access is over a simple 32-bit register bus. The counter and each compare value are split into a low word and a high word at separate addresses.

The counter width is fixed at build time as 32 + 4 × `W_CODE`, and software can read this code back. A stop bit halts counting, and clearing it resumes from the held value. The counter halves are read live, without latching. Software takes a consistent 64-bit sample by reading high, low, high and retrying if the two high reads differ.

Each requesting target (`bus_src`) reaches its own compare register through a local window. It reaches any other target's compare register through a second window, steered by its own other-target select register.

Counting is controlled by a two-state machine:
- `CNT_HALT` is the reset state.
- `CNT_RUN` is the counting state.
- The transition *start* (`CNT_HALT` → `CNT_RUN`) happens on a configuration write with bit 31 = 0.
- The transition *stop* (`CNT_RUN` → `CNT_HALT`) happens on a configuration write with bit 31 = 1.
- Any other configuration write leaves the state as it is.

Word addresses:

| Address | Register |
|---|---|
| 0 | Configuration |
| 1 | Counter low word |
| 2 | Counter high word |
| 3 | Other-target select |
| 4 | Local compare low word |
| 5 | Local compare high word |
| 6 | Other compare low word |
| 7 | Other compare high word |

Top module: `shared_count_timer`

## Requirements
- R1: After reset the counter is 0 and the state is `CNT_HALT`. Every compare value is all ones, every select register is 0, and every interrupt line is low.
- R2: In `CNT_RUN` the counter advances by one each clock. It wraps to 0 after 2^(32+4·W_CODE) − 1.
- R3: Configuration (address 0) reads bit 31 as the stop bit, bits 3:0 as `W_CODE`, and all other bits as 0. Bits 3:0 ignore writes. Writing bit 31 = 1 halts counting from the next clock. Writing 0 resumes counting from the held value.
- R4: Counter bits at or above the configured width read as 0 in the high word (address 2), including after a write of all ones to that word.
- R5: A write to a counter word (address 1 low, address 2 high) loads that word and leaves the other word unchanged. The write takes precedence over the increment in the same cycle.
- R6: The local compare halves (address 4 low, address 5 high) of target `bus_src` are written independently and read back what was written.
- R7: A target's interrupt rises on the clock after the masked counter equals its 64-bit compare value. It then stays high while that compare value is not written.
- R8: Any write to either half of a target's compare value clears its interrupt on that clock. This write wins over a match in the same cycle.
- R9: Each requester has its own select register (address 3, low bits). Addresses 6 and 7 access the compare halves of the target that the requester's select register names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 3 | Word address |
| bus_src | input | TW | Number of the requesting target |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`/`bus_src`, combinational |
| tmr_irq | output | NUM_TGT | Timer interrupt, one per target |

## Verification
A compare match and a compare write can fall on the same clock edge. The bench provokes this by halting the counter and writing the compare low word with the counter's current value twice. The first write clears the interrupt, and the match sets it one clock later. The second write meets the still-active match in the same cycle, so the interrupt must read low after that edge and high one clock later.

A counter-word write can also land on a counting cycle. The bench judges this by reading the exact written value, not that value plus one.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;
    typedef enum logic [2:0] {
        A_CFG     = 3'd0,
        A_CNT_LO  = 3'd1,
        A_CNT_HI  = 3'd2,
        A_OSEL    = 3'd3,
        A_LCMP_LO = 3'd4,
        A_LCMP_HI = 3'd5,
        A_OCMP_LO = 3'd6,
        A_OCMP_HI = 3'd7
    } reg_addr_e;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_HALT = 1'b1
    } cnt_state_e;

    localparam int STOP_BIT = 31;
endpackage

// File: rtl/sct_counter.sv
`timescale 1ns/1ps
module sct_counter
    import sct_pkg::*;
#(
    parameter int W_CODE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_wr,
    input  logic        stop_val,
    input  logic        lo_wr,
    input  logic        hi_wr,
    input  logic [31:0] wdata,
    output logic [63:0] count,
    output logic        halted
);
    localparam int          CW   = 32 + 4 * W_CODE;
    localparam logic [63:0] MASK = (CW >= 64) ? {64{1'b1}} : ((64'd1 << CW) - 64'd1);

    cnt_state_e state_q, state_d;

    // next-state logic: start / stop transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_RUN:  if (stop_wr &&  stop_val) state_d = CNT_HALT;
            CNT_HALT: if (stop_wr && !stop_val) state_d = CNT_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    // counter value: a word write beats the increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (lo_wr)
            count[31:0] <= wdata;
        else if (hi_wr)
            count[63:32] <= wdata & MASK[63:32];
        else if (state_q == CNT_RUN)
            count <= (count + 64'd1) & MASK;
    end

    assign halted = (state_q == CNT_HALT);
endmodule

// File: rtl/sct_cmp.sv
`timescale 1ns/1ps
module sct_cmp (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic [63:0] count,
    output logic [63:0] cmp,
    output logic        irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= {64{1'b1}};
        end else begin
            if (wr_lo) cmp[31:0]  <= wdata;
            if (wr_hi) cmp[63:32] <= wdata;
        end
    end

    // write clears and wins over a match seen in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)              irq <= 1'b0;
        else if (wr_lo || wr_hi) irq <= 1'b0;
        else if (count == cmp)   irq <= 1'b1;
    end
endmodule

// File: rtl/shared_count_timer.sv
`timescale 1ns/1ps
module shared_count_timer
    import sct_pkg::*;
#(
    parameter int NUM_TGT = 4,
    parameter int W_CODE  = 8,
    parameter int TW      = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [2:0]         bus_addr,
    input  logic [TW-1:0]      bus_src,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_TGT-1:0] tmr_irq
);
    reg_addr_e   addr;
    logic [63:0] count;
    logic        halted;
    logic        cnt_wr;
    logic [TW-1:0] osel_q [NUM_TGT];
    logic [TW-1:0] other_tgt;
    logic [63:0] cmp_val [NUM_TGT];
    logic [NUM_TGT-1:0] cmp_wr_lo, cmp_wr_hi, cmp_wr;

    assign addr      = reg_addr_e'(bus_addr);
    assign other_tgt = osel_q[bus_src];
    assign cnt_wr    = bus_wr && (addr == A_CNT_LO || addr == A_CNT_HI);

    sct_counter #(.W_CODE(W_CODE)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_wr (bus_wr && addr == A_CFG),
        .stop_val(bus_wdata[STOP_BIT]),
        .lo_wr   (bus_wr && addr == A_CNT_LO),
        .hi_wr   (bus_wr && addr == A_CNT_HI),
        .wdata   (bus_wdata),
        .count   (count),
        .halted  (halted)
    );

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign cmp_wr_lo[t] = bus_wr &&
            ((addr == A_LCMP_LO && bus_src   == TW'(t)) ||
             (addr == A_OCMP_LO && other_tgt == TW'(t)));
        assign cmp_wr_hi[t] = bus_wr &&
            ((addr == A_LCMP_HI && bus_src   == TW'(t)) ||
             (addr == A_OCMP_HI && other_tgt == TW'(t)));
        assign cmp_wr[t] = cmp_wr_lo[t] | cmp_wr_hi[t];

        always_ff @(posedge clk) begin
            if (!rst_n)
                osel_q[t] <= '0;
            else if (bus_wr && addr == A_OSEL && bus_src == TW'(t))
                osel_q[t] <= bus_wdata[TW-1:0];
        end

        sct_cmp u_cmp (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_lo(cmp_wr_lo[t]),
            .wr_hi(cmp_wr_hi[t]),
            .wdata(bus_wdata),
            .count(count),
            .cmp  (cmp_val[t]),
            .irq  (tmr_irq[t])
        );
    end

    always_comb begin
        unique case (addr)
            A_CFG:     bus_rdata = {halted, 27'd0, 4'(W_CODE)};
            A_CNT_LO:  bus_rdata = count[31:0];
            A_CNT_HI:  bus_rdata = count[63:32];
            A_OSEL:    bus_rdata = 32'(other_tgt);
            A_LCMP_LO: bus_rdata = cmp_val[bus_src][31:0];
            A_LCMP_HI: bus_rdata = cmp_val[bus_src][63:32];
            A_OCMP_LO: bus_rdata = cmp_val[other_tgt][31:0];
            A_OCMP_HI: bus_rdata = cmp_val[other_tgt][63:32];
        endcase
    end
endmodule

// File: rtl/sct_checker.sv
`timescale 1ns/1ps
module sct_checker #(
    parameter int NUM_TGT = 4,
    parameter int W_CODE  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [63:0]        count,
    input logic               halted,
    input logic               cnt_wr,
    input logic [NUM_TGT-1:0] cmp_wr,
    input logic [NUM_TGT-1:0] irq,
    input logic [2:0]         bus_addr,
    input logic [31:0]        bus_rdata
);
    localparam int          CW   = 32 + 4 * W_CODE;
    localparam logic [63:0] MASK = (CW >= 64) ? {64{1'b1}} : ((64'd1 << CW) - 64'd1);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !cnt_wr) |=> (count == (($past(count) + 64'd1) & MASK)));

    a_r3_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !cnt_wr) |=> $stable(count));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd2) |-> ((bus_rdata & ~MASK[63:32]) == 32'd0));

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_chk
        a_r8_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_wr[t] |=> !irq[t]);
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[t] && !cmp_wr[t]) |=> irq[t]);
    end
endmodule

bind shared_count_timer sct_checker #(.NUM_TGT(NUM_TGT), .W_CODE(W_CODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .halted   (halted),
    .cnt_wr   (cnt_wr),
    .cmp_wr   (cmp_wr),
    .irq      (tmr_irq),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/shared_count_timer_tb.sv
`timescale 1ns/1ps
module shared_count_timer_tb;
    localparam int NT = 4;
    localparam int WC = 1;   // 36-bit counter

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [1:0]  bus_src = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [NT-1:0] tmr_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    shared_count_timer #(.NUM_TGT(NT), .W_CODE(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_src(bus_src), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_irq(tmr_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  src;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 3'd0, 32'h8000_0001, 4'd1},  // R1 cfg at reset
        '{1'b0, 2'd0, 3'd1, 32'h0000_0000, 4'd1},  // R1
        '{1'b0, 2'd0, 3'd2, 32'h0000_0000, 4'd1},  // R1
        '{1'b0, 2'd0, 3'd4, 32'hFFFF_FFFF, 4'd1},  // R1
        '{1'b0, 2'd2, 3'd5, 32'hFFFF_FFFF, 4'd1},  // R1
        '{1'b0, 2'd1, 3'd3, 32'h0000_0000, 4'd1},  // R1
        '{1'b1, 2'd0, 3'd4, 32'h0000_1234, 4'd6},  // R6
        '{1'b0, 2'd0, 3'd4, 32'h0000_1234, 4'd6},  // R6
        '{1'b0, 2'd0, 3'd5, 32'hFFFF_FFFF, 4'd6},  // R6
        '{1'b1, 2'd0, 3'd5, 32'h0000_00A5, 4'd6},  // R6
        '{1'b0, 2'd0, 3'd5, 32'h0000_00A5, 4'd6},  // R6
        '{1'b0, 2'd0, 3'd4, 32'h0000_1234, 4'd6},  // R6
        '{1'b1, 2'd0, 3'd0, 32'h8000_000F, 4'd3},  // R3 code bits read-only
        '{1'b0, 2'd0, 3'd0, 32'h8000_0001, 4'd3},  // R3
        '{1'b1, 2'd1, 3'd3, 32'h0000_0003, 4'd9},  // R9
        '{1'b0, 2'd1, 3'd3, 32'h0000_0003, 4'd9},  // R9
        '{1'b0, 2'd0, 3'd3, 32'h0000_0000, 4'd9},  // R9 per-requester
        '{1'b1, 2'd1, 3'd6, 32'h0000_0777, 4'd9},  // R9
        '{1'b0, 2'd3, 3'd4, 32'h0000_0777, 4'd9},  // R9
        '{1'b0, 2'd1, 3'd6, 32'h0000_0777, 4'd9},  // R9
        '{1'b0, 2'd1, 3'd7, 32'hFFFF_FFFF, 4'd9},  // R9
        '{1'b1, 2'd0, 3'd2, 32'hFFFF_FFFF, 4'd4},  // R4
        '{1'b0, 2'd0, 3'd2, 32'h0000_000F, 4'd4},  // R4
        '{1'b0, 2'd0, 3'd1, 32'h0000_0000, 4'd5}   // R5 other word kept
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] a, input logic [31:0] d);
        bus_src = s; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [2:0] a, output logic [31:0] d);
        bus_src = s; bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, h;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", 32'(tmr_irq), 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].src, VEC[i].addr, VEC[i].data);
            end else begin
                rd(VEC[i].src, VEC[i].addr, v);
                check($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].data);
            end
        end

        // R2 wrap at 36 bits, R3 resume from held value
        wr(0, 3'd1, 32'hFFFF_FFFE);
        wr(0, 3'd0, 32'h0000_0000);
        rd(0, 3'd1, v); check("R3 resume held lo", v, 32'hFFFF_FFFE);
        rd(0, 3'd2, h); check("R3 resume held hi", h, 32'h0000_000F);
        tick(1);
        rd(0, 3'd1, v); check("R2 step lo", v, 32'hFFFF_FFFF);
        tick(1);
        rd(0, 3'd1, v); check("R2 wrap lo", v, 32'h0);
        rd(0, 3'd2, h); check("R2 wrap hi", h, 32'h0);

        // R5 write beats increment while running
        wr(0, 3'd1, 32'h10);
        rd(0, 3'd1, v); check("R5 write wins", v, 32'h10);
        tick(1);
        rd(0, 3'd1, v); check("R2 after write", v, 32'h11);

        // R3 stop: increment on the stop edge, then hold
        wr(0, 3'd0, 32'h8000_0000);
        rd(0, 3'd1, v); check("R3 stop edge", v, 32'h12);
        tick(3);
        rd(0, 3'd1, v); check("R3 held", v, 32'h12);
        rd(0, 3'd0, v); check("R3 cfg stopped", v, 32'h8000_0001);

        // R7 match latency and stickiness
        wr(0, 3'd1, 32'd100);
        wr(0, 3'd5, 32'd0);
        wr(0, 3'd4, 32'd103);
        wr(0, 3'd0, 32'h0);
        tick(3);
        rd(0, 3'd1, v); check("R7 count at match", v, 32'd103);
        check("R7 irq not yet", 32'(tmr_irq), 32'd0);
        tick(1);
        check("R7 irq set", 32'(tmr_irq), 32'b0001);
        wr(0, 3'd0, 32'h8000_0000);
        tick(3);
        check("R7 irq sticky", 32'(tmr_irq), 32'b0001);

        // R8 clear through the other-target window
        wr(2, 3'd3, 32'd0);
        wr(2, 3'd7, 32'd0);
        check("R8 other write clears", 32'(tmr_irq), 32'd0);
        rd(0, 3'd5, v); check("R9 other wrote target0", v, 32'd0);

        // R8 write vs simultaneous match
        rd(0, 3'd1, v);
        wr(0, 3'd4, v);
        check("R8 clear on write", 32'(tmr_irq), 32'd0);
        tick(1);
        check("R7 match while halted", 32'(tmr_irq), 32'b0001);
        wr(0, 3'd4, v);
        check("R8 write beats match", 32'(tmr_irq), 32'd0);
        tick(1);
        check("R7 re-match", 32'(tmr_irq), 32'b0001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule